// File: doc/BRIEF.md
# Multicycle Accumulator Processor

This block is a compact processor built around a single accumulator (ACC) and an index register (IX). Instructions and data live in one shared memory of 256 words. A synchronous external memory is attached through a single-port interface that returns read data one cycle after the address. Every instruction passes through a fixed sequence of states. The fetch states move the program counter into the memory address register, read the word and copy it into the memory data and current instruction registers. An execute state then finishes the instruction or branches into the extra memory states it needs.

An instruction is one 16-bit word. Bits [12:8] hold the opcode, bit 14 selects the immediate form, and bits [7:0] hold the operand, which is either a value or an address. Bits 15 and 13 are ignored. Opcodes are: 00 halt, 01 load immediate, 02 load direct, 03 load indirect, 04 load indexed, 05 load IX immediate, 06 store, 07 add, 08 subtract, 09 increment, 0A decrement, 0B jump, 0C compare, 0D jump-if-equal, 0E jump-if-not-equal, 0F and, 10 or, 11 xor, 12 shift left, 13 shift right, 14 input, 15 output, 16 return-from-interrupt. Any other opcode does nothing. A single level-sensitive interrupt request is accepted only at the boundary between instructions.

The sequencer has these states: FETCH (MAR takes PC), IR_RD (read issued), IR_LD (CIR and MDR take the word, PC advances), and EXEC. From EXEC the sequencer goes to one of these:
- HALT, on halt.
- PTR_RD then PTR_LD, on indirect load. PTR_LD moves the pointer into MAR.
- MEM_WR, on store.
- MEM_RD then MEM_LD, on any memory-operand instruction.
- CHECK directly, otherwise.

MEM_RD, MEM_LD and MEM_WR all end in CHECK. CHECK returns to FETCH. It either continues the program or enters the service routine. HALT has no exit except reset.

Top module: `acc_cpu`

## Requirements
- R1: After reset, PC is 0 and execution starts with the word at address 0. Instructions then run from consecutive addresses. An instruction with no memory operand takes 5 clock cycles from FETCH to the next FETCH.
- R2: Opcode 01 loads the zero-extended operand into ACC. Opcode 02 loads Memory[operand] into ACC and takes 7 cycles. Opcode 06 writes ACC to Memory[operand] with exactly one write-enable cycle.
- R3: Opcode 03 reads Memory[operand] and uses its low 8 bits as a second address, then loads that word into ACC. The second read makes it take 9 cycles.
- R4: Opcode 05 loads the zero-extended operand into IX. Opcode 04 loads Memory[(operand + IX) mod 256] into ACC.
- R5: Opcodes 07 (add) and 08 (subtract) use Memory[operand] when bit 14 is 0 and the operand value itself when bit 14 is 1. The result goes to ACC.
- R6: Opcodes 09 (increment) and 0A (decrement) act on ACC when operand bit 0 is 0 and on IX when it is 1. The other register is left unchanged.
- R7: Opcode 0C compares ACC with the operand, using bit 14 as in R5, and keeps only an equality flag. ACC is unchanged. Opcode 0B always loads PC from the operand. Opcodes 0D and 0E load PC only when the flag is set or clear respectively.
- R8: Opcodes 0F, 10 and 11 apply bitwise AND, OR and XOR of ACC with the operand, using bit 14 as in R5.
- R9: Opcodes 12 and 13 shift ACC left or right by the operand value. Vacated bits fill with zero. A shift of 16 or more gives 0.
- R10: Opcode 14 loads the 8-bit input character, zero-extended, into ACC. Opcode 15 puts ACC[7:0] on the character output together with a one-cycle valid pulse.
- R11: The status output is {V, C, N, Z} in bits [3:0]. It is updated only by add, subtract, increment and decrement. C is the carry out on add and the borrow on subtract. Reset clears it.
- R12: A pending request is taken only in CHECK while interrupts are enabled. Taking it gives a one-cycle acknowledge, saves PC and status, masks further requests and jumps to address F0. Opcode 16 restores PC and status and unmasks.
- R13: Opcode 00 enters HALT. From then on the halted output stays high, no memory write or output occurs, and interrupt requests are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level interrupt request, held until acknowledged |
| in_char | input | 8 | Character input port |
| mem_rdata | input | 16 | Read data, valid the cycle after the address |
| irq_ack | output | 1 | One-cycle pulse when the request is taken |
| mem_addr | output | 8 | Memory word address (MAR) |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data (MDR) |
| out_char | output | 8 | Character output port |
| out_valid | output | 1 | One-cycle pulse with each new output character |
| halted | output | 1 | High once halt has executed |
| status | output | 4 | Flags {V, C, N, Z} |

## Verification
The bench builds the processor with its default parameters: 8-bit addresses, 16-bit words and a service routine at F0. With 16-bit words, shifts by 16 can be checked for an all-zero result. With 8-bit addresses, an indexed address of 0x48 + 0xFF wraps around to 0x47. With the service routine at F0, it sits high in memory, clear of the test programs at the bottom. The request is held high across the whole service routine, so the masking decides whether the saved return address survives.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        S_FETCH, S_IR_RD, S_IR_LD, S_EXEC,
        S_PTR_RD, S_PTR_LD, S_MEM_RD, S_MEM_LD,
        S_MEM_WR, S_CHECK, S_HALT
    } state_t;

    typedef enum logic [4:0] {
        OP_HLT = 5'h00, OP_LDM, OP_LDD, OP_LDI, OP_LDX, OP_LDR, OP_STO,
        OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_JMP, OP_CMP, OP_JPE, OP_JPN,
        OP_AND, OP_OR, OP_XOR, OP_LSL, OP_LSR, OP_IN, OP_OUT, OP_RTI
    } op_t;

    typedef enum logic [2:0] {
        F_PASS, F_ADD, F_SUB, F_AND, F_OR, F_XOR, F_SHL, F_SHR
    } alu_fn_t;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flags_t;

    // Instructions that leave EXEC for extra memory cycles
    function automatic logic needs_mem(op_t op, logic imm);
        case (op)
            OP_LDD, OP_LDX, OP_LDI, OP_STO: return 1'b1;
            OP_ADD, OP_SUB, OP_CMP,
            OP_AND, OP_OR, OP_XOR:          return !imm;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_fn_t         fn,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y,
    output flags_t          f
);
    logic [DW:0] sum;
    logic [DW:0] dif;

    assign sum = {1'b0, a} + {1'b0, b};
    assign dif = {1'b0, a} - {1'b0, b};

    always_comb begin
        y   = b;
        f.c = 1'b0;
        f.v = 1'b0;
        unique case (fn)
            F_PASS: y = b;
            F_ADD: begin
                y   = sum[DW-1:0];
                f.c = sum[DW];
                f.v = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
            end
            F_SUB: begin
                y   = dif[DW-1:0];
                f.c = dif[DW];
                f.v = (a[DW-1] != b[DW-1]) && (dif[DW-1] != a[DW-1]);
            end
            F_AND:  y = a & b;
            F_OR:   y = a | b;
            F_XOR:  y = a ^ b;
            F_SHL:  y = a << b;
            F_SHR:  y = a >> b;
            default: y = b;
        endcase
        f.n = y[DW-1];
        f.z = (y == '0);
    end
endmodule

// File: rtl/acc_cpu_fsm.sv
module acc_cpu_fsm
    import acc_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  op_t    op,
    input  logic   imm,
    output state_t state,
    output logic   mem_we,
    output logic   halted,
    output logic   at_boundary
);
    state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_FETCH:  nxt = S_IR_RD;
            S_IR_RD:  nxt = S_IR_LD;
            S_IR_LD:  nxt = S_EXEC;
            S_EXEC: begin
                if (op == OP_HLT)          nxt = S_HALT;
                else if (op == OP_LDI)     nxt = S_PTR_RD;
                else if (op == OP_STO)     nxt = S_MEM_WR;
                else if (needs_mem(op, imm)) nxt = S_MEM_RD;
                else                       nxt = S_CHECK;
            end
            S_PTR_RD: nxt = S_PTR_LD;
            S_PTR_LD: nxt = S_MEM_RD;
            S_MEM_RD: nxt = S_MEM_LD;
            S_MEM_LD: nxt = S_CHECK;
            S_MEM_WR: nxt = S_CHECK;
            S_CHECK:  nxt = S_FETCH;
            S_HALT:   nxt = S_HALT;
            default:  nxt = S_FETCH;
        endcase
    end

    always_comb begin
        mem_we      = (state == S_MEM_WR);
        halted      = (state == S_HALT);
        at_boundary = (state == S_CHECK);
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int               AW       = 8,
    parameter int               DW       = 16,
    parameter int               CW       = 8,
    parameter logic [AW-1:0]    ISR_ADDR = 8'hF0,
    parameter logic [AW-1:0]    RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq,
    input  logic [CW-1:0]   in_char,
    input  logic [DW-1:0]   mem_rdata,
    output logic            irq_ack,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [DW-1:0]   mem_wdata,
    output logic [CW-1:0]   out_char,
    output logic            out_valid,
    output logic            halted,
    output logic [3:0]      status
);
    localparam int OP_LO   = AW;
    localparam int OP_HI   = AW + 4;
    localparam int IMM_BIT = AW + 6;

    state_t          state;
    logic            at_boundary;
    logic [AW-1:0]   pc, mar, sh_pc;
    logic [DW-1:0]   mdr, cir, acc, ix;
    flags_t          flags, sh_flags, alu_f;
    logic            eq, ie;

    op_t             op;
    logic            imm, step, to_ix, apply_now, take;
    logic [AW-1:0]   arg;
    logic [DW-1:0]   arg_ext, a_val, b_val, alu_y;
    alu_fn_t         fn;
    logic            unused_bits;

    assign op          = op_t'(cir[OP_HI:OP_LO]);
    assign imm         = cir[IMM_BIT];
    assign arg         = cir[AW-1:0];
    assign arg_ext     = {{(DW-AW){1'b0}}, arg};
    assign unused_bits = ^{cir[DW-1:IMM_BIT+1], cir[IMM_BIT-1]};

    acc_cpu_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .op(op), .imm(imm), .state(state),
        .mem_we(mem_we), .halted(halted), .at_boundary(at_boundary)
    );

    assign step      = (op == OP_INC) || (op == OP_DEC);
    assign to_ix     = step && arg[0];
    assign apply_now = (state == S_MEM_LD) ||
                       ((state == S_EXEC) && !needs_mem(op, imm));
    assign take      = at_boundary && irq && ie;
    assign a_val     = to_ix ? ix : acc;
    assign b_val     = (state == S_MEM_LD) ? mem_rdata :
                       step ? DW'(1) : arg_ext;

    always_comb begin
        unique case (op)
            OP_ADD, OP_INC:        fn = F_ADD;
            OP_SUB, OP_DEC:        fn = F_SUB;
            OP_AND:                fn = F_AND;
            OP_OR:                 fn = F_OR;
            OP_XOR:                fn = F_XOR;
            OP_LSL:                fn = F_SHL;
            OP_LSR:                fn = F_SHR;
            default:               fn = F_PASS;
        endcase
    end

    acc_cpu_alu #(.DW(DW)) u_alu (
        .fn(fn), .a(a_val), .b(b_val), .y(alu_y), .f(alu_f)
    );

    assign irq_ack   = take;
    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign status    = flags;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc        <= RESET_PC;
            mar       <= '0;
            mdr       <= '0;
            cir       <= '0;
            acc       <= '0;
            ix        <= '0;
            flags     <= '0;
            sh_flags  <= '0;
            sh_pc     <= '0;
            eq        <= 1'b0;
            ie        <= 1'b1;
            out_char  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                S_FETCH:  mar <= pc;
                S_IR_LD: begin
                    mdr <= mem_rdata;
                    cir <= mem_rdata;
                    pc  <= pc + AW'(1);
                end
                S_EXEC: begin
                    if (op == OP_LDX) mar <= arg + ix[AW-1:0];
                    else              mar <= arg;
                    if (op == OP_STO) mdr <= acc;
                end
                S_PTR_LD: mar <= mem_rdata[AW-1:0];
                S_MEM_LD: mdr <= mem_rdata;
                S_CHECK: begin
                    if (take) begin
                        sh_pc    <= pc;
                        sh_flags <= flags;
                        ie       <= 1'b0;
                        pc       <= ISR_ADDR;
                    end
                end
                default: ;
            endcase

            if (apply_now) begin
                case (op)
                    OP_LDM, OP_LDD, OP_LDI, OP_LDX: acc <= b_val;
                    OP_LDR: ix <= arg_ext;
                    OP_ADD, OP_SUB: begin
                        acc   <= alu_y;
                        flags <= alu_f;
                    end
                    OP_INC, OP_DEC: begin
                        if (to_ix) ix  <= alu_y;
                        else       acc <= alu_y;
                        flags <= alu_f;
                    end
                    OP_AND, OP_OR, OP_XOR, OP_LSL, OP_LSR: acc <= alu_y;
                    OP_CMP: eq <= (acc == b_val);
                    OP_JMP: pc <= arg;
                    OP_JPE: if (eq)  pc <= arg;
                    OP_JPN: if (!eq) pc <= arg;
                    OP_IN:  acc <= {{(DW-CW){1'b0}}, in_char};
                    OP_OUT: begin
                        out_char  <= acc[CW-1:0];
                        out_valid <= 1'b1;
                    end
                    OP_RTI: begin
                        pc    <= sh_pc;
                        flags <= sh_flags;
                        ie    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic irq_ack,
    input logic mem_we,
    input logic out_valid,
    input logic halted
);
    // R2: a store drives write enable for one cycle only
    a_r2_store_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R13: halt is permanent until reset
    a_r13_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R13: nothing is written or output while halted
    a_r13_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_we && !out_valid));

    // R12: acknowledge is a single-cycle pulse
    a_r12_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R12: acknowledge only answers a live request, never while halted
    a_r12_ack_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (irq && !halted));

    // R10: output valid is a single-cycle pulse
    a_r10_out_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

bind acc_cpu acc_cpu_chk u_chk (.*);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic [15:0] mem_rdata;
    logic        irq_ack;
    logic [7:0]  mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [7:0]  out_char;
    logic        out_valid;
    logic        halted;
    logic [3:0]  status;

    always #10 clk = ~clk;

    acc_cpu u0 (
        .clk(clk), .rst_n(rst_n), .irq(irq), .in_char(in_char),
        .mem_rdata(mem_rdata), .irq_ack(irq_ack), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .out_char(out_char),
        .out_valid(out_valid), .halted(halted), .status(status)
    );

    // synchronous single-port memory, one cycle read latency
    logic [15:0] mem [256];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    int checks = 0;
    int errors = 0;
    int ack_cnt = 0;
    int out_cnt = 0;
    int we_cnt = 0;
    bit irq_want = 1'b0;
    int irq_budget = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_cnt <= 0;
            out_cnt <= 0;
            we_cnt  <= 0;
        end else begin
            if (irq_ack)   ack_cnt <= ack_cnt + 1;
            if (out_valid) out_cnt <= out_cnt + 1;
            if (mem_we)    we_cnt  <= we_cnt + 1;
        end
    end

    always @(negedge clk) irq <= irq_want && (ack_cnt < irq_budget);

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h40] = 16'h0046;
        mem[8'h41] = 16'h0005;
        mem[8'h44] = 16'hBEEF;
        mem[8'h46] = 16'h5A5A;
        mem[8'h47] = 16'h1234;
        mem[8'h48] = 16'h7FFF;
    endtask

    task automatic run(output int cyc);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not halt actual 0 expected 1");
        end
    endtask

    // {status, pre1, pre2, instr, expected Memory[80]}
    localparam logic [67:0] VEC [19] = '{
        {4'h0, 16'h0100, 16'h0100, 16'h012A, 16'h002A},  // R2 load immediate
        {4'h0, 16'h0100, 16'h0100, 16'h0244, 16'hBEEF},  // R2 load direct
        {4'h0, 16'h0100, 16'h0100, 16'h0340, 16'h5A5A},  // R3 load indirect
        {4'h0, 16'h0505, 16'h0100, 16'h0442, 16'h1234},  // R4 indexed
        {4'h0, 16'h05FF, 16'h0100, 16'h0448, 16'h1234},  // R4 indexed wrap
        {4'h0, 16'h0500, 16'h0110, 16'h4703, 16'h0013},  // R5 add immediate
        {4'h0, 16'h0500, 16'h0110, 16'h0741, 16'h0015},  // R5 add memory
        {4'h6, 16'h0500, 16'h0110, 16'h4811, 16'hFFFF},  // R5 subtract borrow
        {4'h0, 16'h0500, 16'h01FF, 16'h0900, 16'h0100},  // R6 increment ACC
        {4'h6, 16'h0500, 16'h0100, 16'h0A00, 16'hFFFF},  // R6 decrement ACC
        {4'h0, 16'h0500, 16'h01AB, 16'h4F0F, 16'h000B},  // R8 and
        {4'h0, 16'h0500, 16'h010A, 16'h5050, 16'h005A},  // R8 or
        {4'h0, 16'h0500, 16'h01FF, 16'h1144, 16'hBE10},  // R8 xor memory
        {4'h0, 16'h0500, 16'h01AB, 16'h1204, 16'h0AB0},  // R9 shift left
        {4'h0, 16'h0500, 16'h0244, 16'h1303, 16'h17DD},  // R9 shift right
        {4'h0, 16'h0500, 16'h01FF, 16'h1210, 16'h0000},  // R9 shift by 16
        {4'hA, 16'h0500, 16'h0248, 16'h4701, 16'h8000},  // R11 overflow
        {4'h1, 16'h0500, 16'h0101, 16'h0A00, 16'h0000},  // R11 zero
        {4'h0, 16'h0500, 16'h0107, 16'h0901, 16'h0007}   // R6 IX step keeps ACC
    };
    localparam int VREQ [19] = '{2, 2, 3, 4, 4, 5, 5, 5, 6, 6, 8, 8, 8, 9, 9, 9, 11, 11, 6};

    initial begin
        int cyc;
        int acks_before;
        logic [7:0] addr_before;
        int we_before;

        // reset state
        clear_mem();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset halted", {15'd0, halted}, 16'h0000);
        check("R1 reset mem_we", {15'd0, mem_we}, 16'h0000);
        check("R1 reset out_valid", {15'd0, out_valid}, 16'h0000);
        check("R11 reset status", {12'd0, status}, 16'h0000);
        check("R1 reset address", {8'd0, mem_addr}, 16'h0000);

        // table of single-instruction programs
        for (int k = 0; k < 19; k++) begin
            clear_mem();
            mem[0] = VEC[k][63:48];
            mem[1] = VEC[k][47:32];
            mem[2] = VEC[k][31:16];
            mem[3] = 16'h0680;
            mem[4] = 16'h0000;
            run(cyc);
            check($sformatf("R%0d vector %0d result", VREQ[k], k), mem[8'h80], VEC[k][15:0]);
            check($sformatf("R11 vector %0d status", k), {12'd0, status}, {12'd0, VEC[k][67:64]});
        end

        // R1 cycle count of a register-only instruction
        clear_mem();
        mem[0] = 16'h0101; mem[1] = 16'h0000;
        run(cyc);
        check("R1 cycles load immediate + halt", 16'(cyc), 16'd9);

        // R2 direct load cost
        clear_mem();
        mem[0] = 16'h0244; mem[1] = 16'h0000;
        run(cyc);
        check("R2 cycles load direct + halt", 16'(cyc), 16'd11);

        // R3 indirect load extra read
        clear_mem();
        mem[0] = 16'h0340; mem[1] = 16'h0000;
        run(cyc);
        check("R3 cycles load indirect + halt", 16'(cyc), 16'd13);

        // R7 compare and jumps
        clear_mem();
        mem[0]  = 16'h0105; mem[1]  = 16'h4C05; mem[2]  = 16'h0D06;
        mem[3]  = 16'h0111; mem[4]  = 16'h0680; mem[5]  = 16'h0000;
        mem[6]  = 16'h0122; mem[7]  = 16'h4C23; mem[8]  = 16'h0E0B;
        mem[9]  = 16'h0133; mem[10] = 16'h0000; mem[11] = 16'h0D09;
        mem[12] = 16'h0680; mem[13] = 16'h0B10; mem[14] = 16'h0000;
        mem[16] = 16'h0000;
        run(cyc);
        check("R7 compare and jump path", mem[8'h80], 16'h0022);

        // R6 IX increment and decrement seen through indexed load
        clear_mem();
        mem[0] = 16'h0503; mem[1] = 16'h0901; mem[2] = 16'h0901;
        mem[3] = 16'h0A01; mem[4] = 16'h0443; mem[5] = 16'h0680;
        mem[6] = 16'h0000;
        run(cyc);
        check("R6 IX stepped to 4", mem[8'h80], 16'h1234);

        // R10 character input and output
        clear_mem();
        in_char = 8'h41;
        mem[0] = 16'h1400; mem[1] = 16'h4701; mem[2] = 16'h1500;
        mem[3] = 16'h0680; mem[4] = 16'h0000;
        run(cyc);
        check("R10 output character", {8'd0, out_char}, 16'h0042);
        check("R10 output pulses", 16'(out_cnt), 16'd1);
        check("R10 input into ACC", mem[8'h80], 16'h0042);

        // R12 interrupt held high through the service routine
        clear_mem();
        mem[0] = 16'h0101; mem[1] = 16'h0680; mem[2] = 16'h0000;
        mem[8'hF0] = 16'h0A00; mem[8'hF1] = 16'h0681; mem[8'hF2] = 16'h1600;
        irq_budget = 2;
        irq_want = 1'b1;
        run(cyc);
        check("R12 acknowledge count", 16'(ack_cnt), 16'd2);
        check("R12 routine result", mem[8'h81], 16'hFFFF);
        check("R12 resumed main program", mem[8'h80], 16'hFFFF);
        check("R12 status restored", {12'd0, status}, 16'h0000);

        // R13 halted stays quiet even with a request pending
        irq_budget = 100;
        acks_before = ack_cnt;
        addr_before = mem_addr;
        we_before = we_cnt;
        repeat (10) @(negedge clk);
        check("R13 stays halted", {15'd0, halted}, 16'h0001);
        check("R13 no acknowledge", 16'(ack_cnt), 16'(acks_before));
        check("R13 no write", 16'(we_cnt), 16'(we_before));
        check("R13 address frozen", {8'd0, mem_addr}, {8'd0, addr_before});
        irq_want = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule